// File: doc/BRIEF.md
# USART Bit-Rate and Serial Clock Generator

This block makes the timing enables that a USART transmitter and receiver step on. A single 12-bit down-counter divides the system clock by (divisor + 1) and produces a prescaler tick. In asynchronous operation, that tick is the receiver's oversampling enable. A post-divider turns it into the transmit bit enable, with one bit per 16 ticks at normal speed or per 8 ticks at double speed.

In synchronous operation the block handles the serial clock pin in one of two ways. As clock master, it toggles its own serial clock on every prescaler tick and drives it onto the pin. As clock slave, it takes the pin in through a synchronizer and an edge detector. In both cases it issues a data-change strobe on one serial clock edge and a data-sample strobe on the opposite edge. A polarity input chooses which edge is which. The shift registers, framing and the receiver's majority voting sit outside this block and consume the strobes.

Top module: `usart_clkgen`

## Requirements
- R1: A write strobe loads the divisor D into the prescaler at once, whatever the count in progress. If the load happens at edge k, the n-th prescaler tick (n = 1, 2, ...) falls in the cycle that follows edge k + n(D+1) - 1, so ticks repeat every D+1 cycles and D = 0 gives a tick every cycle.
- R2: In asynchronous normal mode (sync_sel = 0, dbl_spd = 0), rx_os_tick pulses for one cycle on every prescaler tick. tx_bit_tick pulses on every 16th tick after the divisor write, and always together with rx_os_tick.
- R3: In asynchronous double-speed mode (sync_sel = 0, dbl_spd = 1), tx_bit_tick pulses on every 8th prescaler tick after the divisor write.
- R4: In synchronous master mode (sync_sel = 1, clk_master = 1), xck_oe is 1. A divisor write clears xck_out to 0, and xck_out then toggles after every prescaler tick, giving a serial clock of fclk / (2(D+1)).
- R5: In synchronous modes, dbl_spd has no effect on any output.
- R6: In synchronous slave mode (sync_sel = 1, clk_master = 0), xck_oe and xck_out are 0. A level change on xck_in that is applied before edge c produces its edge strobe in the cycle after edge c+1, which is two cycles of latency.
- R7: In synchronous modes with edge_pol = 0, chg_stb marks rising serial clock edges and smp_stb marks falling ones. With edge_pol = 1 the roles swap. The two strobes never pulse in the same cycle, and tx_bit_tick equals chg_stb.
- R8: rx_os_tick stays 0 in synchronous modes, and chg_stb and smp_stb stay 0 in asynchronous modes.
- R9: While rst_n is low, tx_bit_tick, rx_os_tick, chg_stb, smp_stb, xck_out and xck_oe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_val | input | 12 | Prescaler divisor D (0 to 4095) |
| div_wr | input | 1 | Load strobe for div_val; restarts prescaler and post-divider |
| dbl_spd | input | 1 | Double-speed select, used in asynchronous mode only |
| sync_sel | input | 1 | 0 asynchronous, 1 synchronous |
| clk_master | input | 1 | In synchronous mode: 1 drive serial clock, 0 accept it |
| edge_pol | input | 1 | 0: change on rising, sample on falling; 1: the reverse |
| xck_in | input | 1 | Serial clock pin input (slave mode) |
| tx_bit_tick | output | 1 | Transmit bit enable, one cycle |
| rx_os_tick | output | 1 | Receive oversample enable, one cycle |
| chg_stb | output | 1 | Synchronous data-change strobe |
| smp_stb | output | 1 | Synchronous data-sample strobe |
| xck_out | output | 1 | Serial clock output level |
| xck_oe | output | 1 | Serial clock output enable |

## Verification
After a divisor write at edge k, the prescaler-derived results (rx_os_tick, tx_bit_tick and the master-mode strobes) are combinational from the counter. They are therefore due in the cycle after edge k + n(D+1) - 1, and xck_out shows the toggle one cycle after each tick. In slave mode, a strobe is due exactly two cycles after the cycle in which the bench changes xck_in. The driver turns these formulas into per-output queues of expected cycle numbers before it applies the stimulus. The monitor samples every output 2 ns after the falling edge and compares each strobe it sees with the head of its queue. Checking runs only inside a window that opens at edge k, and at the window's end any expected strobe still queued counts as missed.

// File: rtl/ucg_pkg.sv
package ucg_pkg;

   typedef enum logic [1:0] {
      CM_ASYNC_NORM  = 2'd0,
      CM_ASYNC_DBL   = 2'd1,
      CM_SYNC_MASTER = 2'd2,
      CM_SYNC_SLAVE  = 2'd3
   } clk_mode_e;

   // Double speed is only meaningful when not synchronous.
   function automatic clk_mode_e mode_of(input logic sync_sel,
                                         input logic is_master,
                                         input logic dbl);
      if (sync_sel)
         return is_master ? CM_SYNC_MASTER : CM_SYNC_SLAVE;
      return dbl ? CM_ASYNC_DBL : CM_ASYNC_NORM;
   endfunction

endpackage

// File: rtl/ucg_prescaler.sv
module ucg_prescaler #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic             div_wr,
   output logic             pre_tick
);

   if (DIV_W < 1) begin : g_bad_w
      $error("ucg_prescaler: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt_q;

   assign pre_tick = rst_n && !div_wr && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (div_wr || cnt_q == '0)
         cnt_q <= div_val;
      else
         cnt_q <= cnt_q - 1'b1;
   end

   // R1
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_wr |=> (cnt_q == $past(div_val)));

endmodule

// File: rtl/ucg_postdiv.sv
module ucg_postdiv #(
   parameter int NORM_RATIO = 16,
   parameter int DBL_RATIO  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic pre_tick,
   input  logic use_dbl,
   output logic tx_tick
);

   localparam int CW = (NORM_RATIO > 2) ? $clog2(NORM_RATIO) : 1;
   localparam logic [CW-1:0] NORM_LAST = CW'(NORM_RATIO - 1);
   localparam logic [CW-1:0] DBL_LAST  = CW'(DBL_RATIO - 1);

   if (DBL_RATIO < 2 || NORM_RATIO <= DBL_RATIO) begin : g_bad_ratio
      $error("ucg_postdiv: need 2 <= DBL_RATIO < NORM_RATIO");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last;
   logic          at_last;

   assign last    = use_dbl ? DBL_LAST : NORM_LAST;
   assign at_last = (cnt_q >= last);
   assign tx_tick = pre_tick && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (pre_tick)
         cnt_q <= at_last ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/ucg_xck_master.sv
module ucg_xck_master (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   input  logic pre_tick,
   output logic xck_q,
   output logic rise_stb,
   output logic fall_stb
);

   logic step;

   assign step     = run && pre_tick;
   assign rise_stb = step && !xck_q;
   assign fall_stb = step &&  xck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         xck_q <= 1'b0;
      else if (clr || !run)
         xck_q <= 1'b0;
      else if (step)
         xck_q <= ~xck_q;
   end

endmodule

// File: rtl/ucg_xck_edge.sv
module ucg_xck_edge #(
   parameter int SYNC_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic xck_pin,
   output logic rise_stb,
   output logic fall_stb
);

   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 1) begin : g_bad_stages
      $error("ucg_xck_edge: SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise_q;
   logic                   fall_q;

   if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= xck_pin;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], xck_pin};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         prev_q <= sync_q[LAST];
         rise_q <=  sync_q[LAST] && !prev_q;
         fall_q <= !sync_q[LAST] &&  prev_q;
      end
   end

   assign rise_stb = rise_q;
   assign fall_stb = fall_q;

   // R6
   edge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_q[LAST]) |=> rise_q);

   // R6
   edge_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sync_q[LAST]) |=> fall_q);

endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
   import ucg_pkg::*;
#(
   parameter int DIV_W       = 12,
   parameter int NORM_RATIO  = 16,
   parameter int DBL_RATIO   = 8,
   parameter int SYNC_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic             div_wr,
   input  logic             dbl_spd,
   input  logic             sync_sel,
   input  logic             clk_master,
   input  logic             edge_pol,
   input  logic             xck_in,
   output logic             tx_bit_tick,
   output logic             rx_os_tick,
   output logic             chg_stb,
   output logic             smp_stb,
   output logic             xck_out,
   output logic             xck_oe
);

   clk_mode_e mode_w;
   logic      use_dbl, drive_clk, take_clk, is_async;
   logic      pre_tick, async_tx;
   logic      m_rise, m_fall, s_rise, s_fall;
   logic      edge_r, edge_f;
   logic      m_xck;

   assign mode_w = mode_of(sync_sel, clk_master, dbl_spd);

   always_comb begin
      use_dbl   = 1'b0;
      drive_clk = 1'b0;
      take_clk  = 1'b0;
      is_async  = 1'b0;
      unique case (mode_w)
         CM_ASYNC_NORM:  is_async = 1'b1;
         CM_ASYNC_DBL:   begin is_async = 1'b1; use_dbl = 1'b1; end
         CM_SYNC_MASTER: drive_clk = 1'b1;
         CM_SYNC_SLAVE:  take_clk = 1'b1;
         default:        is_async = 1'b1;
      endcase
   end

   ucg_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_val  (div_val),
      .div_wr   (div_wr),
      .pre_tick (pre_tick)
   );

   ucg_postdiv #(.NORM_RATIO(NORM_RATIO), .DBL_RATIO(DBL_RATIO)) u_post (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (div_wr),
      .pre_tick (pre_tick),
      .use_dbl  (use_dbl),
      .tx_tick  (async_tx)
   );

   ucg_xck_master u_mst (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (div_wr),
      .run      (drive_clk),
      .pre_tick (pre_tick),
      .xck_q    (m_xck),
      .rise_stb (m_rise),
      .fall_stb (m_fall)
   );

   ucg_xck_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .xck_pin  (xck_in),
      .rise_stb (s_rise),
      .fall_stb (s_fall)
   );

   assign edge_r = (drive_clk && m_rise) || (take_clk && s_rise);
   assign edge_f = (drive_clk && m_fall) || (take_clk && s_fall);

   assign chg_stb     = edge_pol ? edge_f : edge_r;
   assign smp_stb     = edge_pol ? edge_r : edge_f;
   assign tx_bit_tick = is_async ? async_tx : chg_stb;
   assign rx_os_tick  = is_async && pre_tick;
   assign xck_out     = m_xck;
   assign xck_oe      = rst_n && drive_clk;

   // R8
   async_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_sel |-> (!chg_stb && !smp_stb));

   // R8
   sync_norx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_sel |-> !rx_os_tick);

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({chg_stb, smp_stb}));

   // R2
   tx_on_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_bit_tick && !sync_sel) |-> rx_os_tick);

   // R4
   master_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_sel && clk_master) |-> xck_oe);

endmodule

// File: tb/usart_clkgen_test.sv
`timescale 1ns/1ps
module usart_clkgen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] div_val = '0;
   logic        div_wr = 1'b0;
   logic        dbl_spd = 1'b0;
   logic        sync_sel = 1'b0;
   logic        clk_master = 1'b0;
   logic        edge_pol = 1'b0;
   logic        xck_in = 1'b0;
   logic        tx_bit_tick, rx_os_tick, chg_stb, smp_stb, xck_out, xck_oe;

   always #4 clk = ~clk;

   usart_clkgen uut (
      .clk(clk), .rst_n(rst_n), .div_val(div_val), .div_wr(div_wr),
      .dbl_spd(dbl_spd), .sync_sel(sync_sel), .clk_master(clk_master),
      .edge_pol(edge_pol), .xck_in(xck_in), .tx_bit_tick(tx_bit_tick),
      .rx_os_tick(rx_os_tick), .chg_stb(chg_stb), .smp_stb(smp_stb),
      .xck_out(xck_out), .xck_oe(xck_oe)
   );

   int    cyc = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   int    expq[4][$];
   string nm[4] = '{"tx_bit_tick", "rx_os_tick", "chg_stb", "smp_stb"};
   string cur_tag = "";
   bit    mon_on = 1'b0;
   bit    cur_master = 1'b0;
   int    cur_k = 0;
   int    cur_d = 0;
   int    win_lo = 0;
   int    win_hi = -1;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic note_event(int idx);
      int e;
      n_chk++;
      if (expq[idx].size() == 0) begin
         n_fail++;
         $display("FAIL %s %s: strobe at cycle %0d, expected none", cur_tag, nm[idx], cyc);
      end else begin
         e = expq[idx].pop_front();
         if (e != cyc) begin
            n_fail++;
            $display("FAIL %s %s: strobe at cycle %0d, expected cycle %0d", cur_tag, nm[idx], cyc, e);
         end
      end
   endtask

   // Monitor: samples 2 ns after the falling edge.
   always @(negedge clk) begin
      logic exp_x;
      #2;
      if (mon_on && cyc >= win_lo && cyc <= win_hi) begin
         if (tx_bit_tick) note_event(0);
         if (rx_os_tick)  note_event(1);
         if (chg_stb)     note_event(2);
         if (smp_stb)     note_event(3);
         exp_x = cur_master ? ((((cyc - cur_k) / (cur_d + 1)) % 2) != 0) : 1'b0;
         n_chk++;
         if (xck_out !== exp_x || xck_oe !== cur_master) begin
            n_fail++;
            $display("FAIL %s xck_out/xck_oe at cycle %0d: got %b/%b expected %b/%b",
                     cur_tag, cyc, xck_out, xck_oe, exp_x, cur_master);
         end
      end
   end

   task automatic open_window(string tag, int k, int w, int d, bit mst);
      for (int i = 0; i < 4; i++) expq[i].delete();
      cur_tag    = tag;
      cur_k      = k;
      cur_d      = d;
      cur_master = mst;
      win_lo     = k;
      win_hi     = k + w - 1;
   endtask

   task automatic close_window();
      while (cyc <= win_hi) @(negedge clk);
      mon_on = 1'b0;
      for (int i = 0; i < 4; i++) begin
         n_chk++;
         if (expq[i].size() != 0) begin
            n_fail++;
            $display("FAIL %s %s: %0d strobes missing, got none at cycle %0d, expected one there",
                     cur_tag, nm[i], expq[i].size(), expq[i][0]);
         end
         expq[i].delete();
      end
   endtask

   // Asynchronous run: R1, R2, R3
   task automatic run_async(string tag, int d, bit dbl, int w);
      int k;
      int ratio;
      ratio = dbl ? 8 : 16;
      @(negedge clk);
      sync_sel = 1'b0; clk_master = 1'b0; edge_pol = 1'b0; dbl_spd = dbl;
      div_val = 12'(d); div_wr = 1'b1;
      k = cyc + 1;
      open_window(tag, k, w, d, 1'b0);
      for (int n = 1; k + n * (d + 1) - 1 <= win_hi; n++) begin
         expq[1].push_back(k + n * (d + 1) - 1);
         if (n % ratio == 0) expq[0].push_back(k + n * (d + 1) - 1);
      end
      mon_on = 1'b1;
      @(negedge clk);
      div_wr = 1'b0;
      close_window();
   endtask

   // Synchronous master run: R4, R5, R7, R8
   task automatic run_master(string tag, int d, bit pol, bit dbl, int w);
      int k;
      int t;
      @(negedge clk);
      sync_sel = 1'b1; clk_master = 1'b1; edge_pol = pol; dbl_spd = dbl;
      div_val = 12'(d); div_wr = 1'b1;
      k = cyc + 1;
      open_window(tag, k, w, d, 1'b1);
      for (int n = 1; k + n * (d + 1) - 1 <= win_hi; n++) begin
         t = k + n * (d + 1) - 1;
         // odd tick = rising edge of the serial clock
         if ((n % 2 == 1) != pol) begin
            expq[2].push_back(t);
            expq[0].push_back(t);
         end else begin
            expq[3].push_back(t);
         end
      end
      mon_on = 1'b1;
      @(negedge clk);
      div_wr = 1'b0;
      close_window();
   endtask

   // Synchronous slave run: R6, R7, R8
   task automatic run_slave(string tag, bit pol, bit dbl, int h, int nt);
      int c0;
      @(negedge clk);
      sync_sel = 1'b1; clk_master = 1'b0; edge_pol = pol; dbl_spd = dbl;
      c0 = cyc;
      open_window(tag, c0 + 1, h * nt + 3, 0, 1'b0);
      for (int i = 0; i < nt; i++) begin
         // even-indexed toggle takes the pin high
         if ((i % 2 == 0) != pol) begin
            expq[2].push_back(c0 + h * (i + 1) + 2);
            expq[0].push_back(c0 + h * (i + 1) + 2);
         end else begin
            expq[3].push_back(c0 + h * (i + 1) + 2);
         end
      end
      mon_on = 1'b1;
      for (int i = 0; i < nt; i++) begin
         repeat (h) @(negedge clk);
         xck_in = ~xck_in;
      end
      close_window();
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      // R9: outputs quiet while reset is held, even with master mode selected
      sync_sel = 1'b1; clk_master = 1'b1;
      repeat (3) @(negedge clk);
      #2;
      n_chk++;
      if ({tx_bit_tick, rx_os_tick, chg_stb, smp_stb, xck_out, xck_oe} !== 6'b0) begin
         n_fail++;
         $display("FAIL R9 reset outputs: got %b expected 000000",
                  {tx_bit_tick, rx_os_tick, chg_stb, smp_stb, xck_out, xck_oe});
      end
      @(negedge clk);
      rst_n = 1'b1;
      sync_sel = 1'b0; clk_master = 1'b0;
      repeat (2) @(negedge clk);

      run_async("R1/R2 normal D=3", 3, 1'b0, 200);
      run_async("R1/R2 normal D=0", 0, 1'b0, 70);
      run_async("R3 double D=5", 5, 1'b0 ^ 1'b1, 150);
      run_async("R1 rewrite D=11", 11, 1'b0, 40);
      run_async("R1 rewrite D=2", 2, 1'b0, 120);
      run_async("R1/R3 double D=4095", 4095, 1'b1, 8 * 4096 + 10);
      run_master("R4/R7/R8 master pol0", 2, 1'b0, 1'b0, 60);
      run_master("R5/R7 master pol1 dbl", 2, 1'b1, 1'b1, 60);
      run_master("R4 master D=0", 0, 1'b0, 1'b0, 30);
      run_slave("R6/R7/R8 slave pol0", 1'b0, 1'b0, 3, 8);
      run_slave("R5/R6/R7 slave pol1 dbl", 1'b1, 1'b1, 5, 6);
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run still busy at cycle %0d, expected done", cyc);
      finish_run();
   end

endmodule